// File: doc/BRIEF.md
# SLC-96 Transmit Framing-Bit Inserter

This block sits next to a D4 T1 transmit framer and supplies the framing bit for every frame of a 72-frame multiframe. The multiframe is six 12-frame superframes. Every frame with an odd frame number is a terminal-framing slot and carries the fixed 1,0,1,0,1,0 pattern. Every frame with an even frame number is a signalling-framing slot. Of these 36 signalling-framing slots, 12 carry a fixed alignment sequence and 24 carry message bits that a host supplies one byte per superframe.

The framer pulses `frame_stb` once per frame. One cycle later the block presents the framing bit for that frame on `fbit`, with a one-cycle `fbit_vld` pulse. At the first frame of each superframe the block takes the most recently written byte into its working register and raises `req`. The host answers with a write, which clears `req`. That byte then drives the message slots of the next superframe. If the host misses a superframe, the block repeats the last byte and sets the sticky `underrun` flag. When `en` is low, the block behaves like a plain D4 source and raises no requests.

Top module: `slc96_tx_link`

## Requirements
- R1: After reset, `fbit`, `fbit_vld`, `req` and `underrun` are 0. A `frame_stb` pulse sampled at a clock edge gives `fbit_vld`=1 and the frame's bit on `fbit` in the next cycle. Without a strobe, `fbit_vld` is 0 and `fbit` holds its value.
- R2: Frame positions 0,2,4,6,8,10 within a superframe (the odd frame numbers 1,3,...,11) output 1,0,1,0,1,0, whatever the values of `en` and the host data.
- R3: With `en`=1, the first two odd positions (1 and 3) of each superframe are alignment slots. Across superframes 0..5, in order, these 12 slots output 000111000111, whatever byte has been written.
- R4: With `en`=1, positions 5,7,9,11 of a superframe output bits 7,6,5,4 of that superframe's working byte, MSB first. Bits 3..0 of the byte are never output.
- R5: At a strobe on position 0 with `en`=1, the working byte becomes the most recently written byte (0 if none since reset) and `req` is 1 in the next cycle.
- R6: A host write (`wr_en`=1) that does not coincide with a superframe-start strobe clears `req` in the next cycle and stores `wr_data` as the next byte.
- R7: If `req` is still 1 at a superframe start with `en`=1, the previous byte is reused and `underrun` becomes 1. It then stays 1 until reset.
- R8: With `en`=0, the odd positions 1,3,5,7,9,11 output 0,0,1,1,1,0. `req` is 0 from the next cycle on, and `underrun` is not set.
- R9: The position counter advances on every strobe regardless of `en`. It wraps after 12 frames per superframe and after 6 superframes, so the multiframe is 72 frames long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One pulse per T1 frame |
| en | input | 1 | 1: message mode, 0: plain D4 framing |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host message byte |
| fbit | output | 1 | Framing bit of the last strobed frame |
| fbit_vld | output | 1 | Pulses one cycle after each strobe |
| req | output | 1 | Host byte request |
| underrun | output | 1 | Sticky missed-refill flag |

## Verification
The assertions assume that `frame_stb` is a single-cycle pulse that starts counting from the first strobe after reset. They also assume that a host write never lands in the same cycle as a superframe-start strobe, because that cycle has a defined but special merge behaviour that the properties do not model. The stimulus drives strobes separated by at least one idle cycle. It places host writes only between strobes, at a random frame of the superframe. It toggles `en` only between strobes, so every property sees a clean position sequence.

// File: rtl/slc96_pkg.sv
package slc96_pkg;
  typedef enum logic [1:0] {
    SLOT_FT    = 2'd0,
    SLOT_ALIGN = 2'd1,
    SLOT_MSG   = 2'd2,
    SLOT_D4    = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/slc96_mf_cnt.sv
module slc96_mf_cnt #(
  parameter int SF_LEN = 12,
  parameter int SF_NUM = 6,
  localparam int POS_W = $clog2(SF_LEN),
  localparam int SF_W  = $clog2(SF_NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  output logic [POS_W-1:0] pos,
  output logic [SF_W-1:0]  sf,
  output logic             sf_start
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SF_LEN - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SF_NUM - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      sf  <= '0;
    end else if (stb) begin
      if (pos == POS_LAST) begin
        pos <= '0;
        sf  <= (sf == SF_LAST) ? '0 : sf + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign sf_start = (pos == '0);
endmodule

// File: rtl/slc96_host_if.sv
module slc96_host_if #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              stb,
  input  logic              sf_start,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] work_byte,
  output logic              req,
  output logic              underrun
);
  logic [BYTE_W-1:0] next_byte;
  logic              boundary;

  assign boundary = stb && sf_start && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_byte <= '0;
      work_byte <= '0;
      req       <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (wr_en) next_byte <= wr_data;
      if (!en) begin
        req <= 1'b0;
      end else if (boundary) begin
        work_byte <= wr_en ? wr_data : next_byte;
        req       <= 1'b1;
        if (req && !wr_en) underrun <= 1'b1;
      end else if (wr_en) begin
        req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slc96_fbit_gen.sv
module slc96_fbit_gen
  import slc96_pkg::*;
#(
  parameter int SF_LEN       = 12,
  parameter int SF_NUM       = 6,
  parameter int BYTE_W       = 8,
  parameter int ALIGN_PER_SF = 2,
  localparam int POS_W       = $clog2(SF_LEN),
  localparam int SF_W        = $clog2(SF_NUM),
  localparam int HALF        = SF_LEN / 2,
  localparam int ALIGN_LEN   = ALIGN_PER_SF * SF_NUM,
  parameter logic [HALF-1:0]      FT_SEQ    = 6'b101010,
  parameter logic [HALF-1:0]      D4_FS_SEQ = 6'b001110,
  parameter logic [ALIGN_LEN-1:0] ALIGN_SEQ = 12'b000111000111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              en,
  input  logic [POS_W-1:0]  pos,
  input  logic [SF_W-1:0]   sf,
  input  logic [BYTE_W-1:0] work_byte,
  output logic              fbit,
  output logic              fbit_vld
);
  localparam int MSG_PER_SF = HALF - ALIGN_PER_SF;
  localparam int HALF_IW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int ALIGN_IW   = (ALIGN_LEN > 1) ? $clog2(ALIGN_LEN) : 1;
  localparam int BYTE_IW    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  slot_kind_e          kind;
  int                  slot;
  logic [HALF_IW-1:0]  half_idx;
  logic [ALIGN_IW-1:0] align_idx;
  logic [BYTE_IW-1:0]  msg_idx;
  logic                bit_d;
  logic                unused_low_bits;

  assign unused_low_bits = ^work_byte[BYTE_W-MSG_PER_SF-1:0];

  always_comb begin
    slot      = int'(pos) / 2;
    half_idx  = HALF_IW'(HALF - 1 - slot);
    align_idx = ALIGN_IW'(ALIGN_LEN - 1 - (int'(sf) * ALIGN_PER_SF + slot));
    msg_idx   = BYTE_IW'(BYTE_W - 1 - (slot - ALIGN_PER_SF));
    if (!pos[0])                 kind = SLOT_FT;
    else if (!en)                kind = SLOT_D4;
    else if (slot < ALIGN_PER_SF) kind = SLOT_ALIGN;
    else                         kind = SLOT_MSG;
    unique case (kind)
      SLOT_FT:    bit_d = FT_SEQ[half_idx];
      SLOT_D4:    bit_d = D4_FS_SEQ[half_idx];
      SLOT_ALIGN: bit_d = ALIGN_SEQ[align_idx];
      default:    bit_d = work_byte[msg_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fbit     <= 1'b0;
      fbit_vld <= 1'b0;
    end else begin
      fbit_vld <= stb;
      if (stb) fbit <= bit_d;
    end
  end
endmodule

// File: rtl/slc96_tx_link.sv
module slc96_tx_link #(
  parameter int SF_LEN       = 12,
  parameter int SF_NUM       = 6,
  parameter int BYTE_W       = 8,
  parameter int ALIGN_PER_SF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              fbit,
  output logic              fbit_vld,
  output logic              req,
  output logic              underrun
);
  localparam int POS_W = $clog2(SF_LEN);
  localparam int SF_W  = $clog2(SF_NUM);

  logic [POS_W-1:0]  pos;
  logic [SF_W-1:0]   sf;
  logic              sf_start;
  logic [BYTE_W-1:0] work_byte;

  slc96_mf_cnt #(.SF_LEN(SF_LEN), .SF_NUM(SF_NUM)) cnt_i (
    .clk(clk), .rst(rst), .stb(frame_stb),
    .pos(pos), .sf(sf), .sf_start(sf_start)
  );

  slc96_host_if #(.BYTE_W(BYTE_W)) host_i (
    .clk(clk), .rst(rst), .en(en), .stb(frame_stb), .sf_start(sf_start),
    .wr_en(wr_en), .wr_data(wr_data),
    .work_byte(work_byte), .req(req), .underrun(underrun)
  );

  slc96_fbit_gen #(
    .SF_LEN(SF_LEN), .SF_NUM(SF_NUM), .BYTE_W(BYTE_W), .ALIGN_PER_SF(ALIGN_PER_SF)
  ) gen_i (
    .clk(clk), .rst(rst), .stb(frame_stb), .en(en),
    .pos(pos), .sf(sf), .work_byte(work_byte),
    .fbit(fbit), .fbit_vld(fbit_vld)
  );
endmodule

// File: rtl/slc96_tx_link_chk.sv
module slc96_tx_link_chk #(
  parameter int SF_LEN = 12
) (
  input logic clk,
  input logic rst,
  input logic frame_stb,
  input logic en,
  input logic wr_en,
  input logic fbit,
  input logic fbit_vld,
  input logic req,
  input logic underrun
);
  localparam int PW = $clog2(SF_LEN);
  logic [PW-1:0] chk_pos;

  always_ff @(posedge clk) begin
    if (rst) chk_pos <= '0;
    else if (frame_stb) chk_pos <= (chk_pos == PW'(SF_LEN - 1)) ? '0 : chk_pos + 1'b1;
  end

  a_r1_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> fbit_vld);
  a_r1_no_vld_idle: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> !fbit_vld);
  a_r1_bit_holds: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(fbit));
  a_r2_ft_pattern: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !chk_pos[0]) |=> (fbit == !$past(chk_pos[1])));
  a_r5_req_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(frame_stb && en && chk_pos == '0));
  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(frame_stb && chk_pos == '0)) |=> !req);
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  a_r8_no_req_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req);
endmodule

bind slc96_tx_link slc96_tx_link_chk #(.SF_LEN(SF_LEN)) chk_i (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .en(en), .wr_en(wr_en),
  .fbit(fbit), .fbit_vld(fbit_vld), .req(req), .underrun(underrun)
);

// File: tb/slc96_tx_link_tb_top.sv
module slc96_tx_link_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fbit, fbit_vld, req, underrun;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int m_pos = 0, m_sf = 0;
  logic [7:0] m_hold = 8'h00, m_act = 8'h00;
  bit m_req = 0, m_und = 0;

  always #10 clk = ~clk;

  slc96_tx_link dut_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .en(en), .wr_en(wr_en),
    .wr_data(wr_data), .fbit(fbit), .fbit_vld(fbit_vld), .req(req), .underrun(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int pos, input int sf, input bit e, input logic [7:0] b);
    logic [5:0]  d4 = 6'b001110;
    logic [11:0] al = 12'b000111000111;
    int j = pos / 2;
    if (pos % 2 == 0) return (j % 2 == 0);
    if (!e) return d4[5 - j];
    if (j < 2) return al[11 - (sf * 2 + j)];
    return b[7 - (j - 2)];
  endfunction

  function automatic string tag_of(input int pos, input bit e);
    if (pos % 2 == 0) return "R2 ft";
    if (!e) return "R8 d4";
    if (pos < 5) return "R3 align";
    return "R4 msg";
  endfunction

  task automatic frame_step();
    bit e;
    @(negedge clk);
    frame_stb = 1'b1;
    e = en;
    if (e && m_pos == 0) begin
      if (m_req) m_und = 1;
      m_act = m_hold;
      m_req = 1;
    end
    @(negedge clk);
    frame_stb = 1'b0;
    chk({tag_of(m_pos, e), " fbit"}, fbit, exp_bit(m_pos, m_sf, e, m_act));
    chk("R1 vld", fbit_vld, 1);
    chk("R5 req", req, m_req);
    chk("R7 underrun", underrun, m_und);
    if (m_pos == 11) begin
      m_pos = 0;
      m_sf = (m_sf == 5) ? 0 : m_sf + 1;
    end else m_pos++;
    @(negedge clk);
    chk("R1 vld idle", fbit_vld, 0);
  endtask

  task automatic host_write(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    m_hold = b;
    @(negedge clk);
    wr_en = 1'b0;
    m_req = 0;
    chk("R6 req cleared", req, 0);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    en = v;
    if (!v) m_req = 0;
    @(negedge clk);
    chk("R8 req with en", req, m_req);
  endtask

  task automatic run_sf(input bit do_write, input logic [7:0] b, input int at);
    for (int f = 0; f < 12; f++) begin
      frame_step();
      if (do_write && f == at) host_write(b);
    end
  endtask

  initial begin
    void'($urandom(32'h5C96_0001));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset fbit", fbit, 0);
    chk("R1 reset vld", fbit_vld, 0);
    chk("R1 reset req", req, 0);
    chk("R1 reset underrun", underrun, 0);

    set_en(1);
    // R4/R5: one byte per superframe; the low nibble is never output
    run_sf(1, 8'hA3, 0);
    run_sf(1, 8'h5C, 4);
    run_sf(1, 8'hF0, 11);
    run_sf(1, 8'h0F, 2);
    run_sf(1, 8'h96, 7);
    run_sf(1, 8'h6E, 0);
    // R9: second multiframe, alignment restarts at superframe 0
    run_sf(1, 8'h3B, 1);
    // R7: missed refill, byte repeats and the sticky flag sets
    run_sf(0, 8'h00, 0);
    run_sf(0, 8'h00, 0);
    run_sf(1, 8'hC7, 5);
    // R8: plain D4, writes still accepted but no request
    set_en(0);
    for (int s = 0; s < 6; s++) run_sf(s % 2 == 0, 8'h81 + 8'(s), 3);
    set_en(1);
    // random mix
    for (int s = 0; s < 30; s++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) set_en(!en);
      run_sf(r != 1, 8'($urandom), $urandom_range(0, 11));
    end
    chk("R7 underrun final", underrun, m_und);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule